// File: doc/BRIEF.md
# Loop Branch Predictor with Target-Buffer Filtering

This block guesses, for each fetched instruction address, whether a branch lives there, whether it will be taken, and where it will go. Two structures work together. A direct-mapped, tagged target buffer records branches that have been seen taken, along with their destinations. A pattern table, selected only by low address bits, holds the direction state. The pattern table has a fixed number of storage bits. A mode input decides how those bits are used: either as one last-outcome bit per entry, or as a two-bit saturating counter per entry. One-bit mode therefore has twice as many entries and consumes one more address bit for its index.

The fetch side presents an address and receives, within the same cycle, a hit flag, a taken guess and the next fetch address. The resolve side reports a retired branch with its address, its real direction and its real destination. The block learns from that report at the next clock edge. A branch that resolves not-taken and is absent from the target buffer leaves every piece of state alone, as if it had never been a branch. This keeps branches that never jump from disturbing the shared pattern entries.

Top module: `lbp_top`

## Requirements
- R1: After reset every target-buffer slot is invalid and every pattern entry reads not-taken, so any fetch address gives pred_hit=0, pred_taken=0 and pred_next_pc=fetch_pc+4.
- R2: pred_taken is 1 only when the target buffer hits and the selected pattern entry predicts taken, and in that case pred_next_pc is the stored destination. In every other case pred_next_pc is fetch_pc+4.
- R3: A resolved branch that is not taken and misses in the target buffer changes neither the target buffer nor the pattern table.
- R4: A resolved taken branch that misses in the target buffer claims its slot and writes tag and destination. Its pattern entry is set to value 2 (weakly taken) in two-bit mode, or to 1 (taken) in one-bit mode.
- R5: In two-bit mode each entry counts 0..3 and saturates at both ends. Values 2 and 3 predict taken. A hit that resolves taken adds one and a hit that resolves not-taken subtracts one, so a single not-taken outcome leaves a value of 3 still predicting taken.
- R6: In one-bit mode a resolved branch that hits in the target buffer stores its real direction as the entry value (1 = taken).
- R7: A taken branch that hits in the target buffer with a different stored destination replaces the destination with the resolved one.
- R8: The target buffer slot is fetch_pc[5:2] and its tag is fetch_pc[31:6]. The pattern index is fetch_pc[4:2] in two-bit mode and fetch_pc[5:2] in one-bit mode. Both modes use the same 16 storage bits. Branches that share an index share one entry.
- R9: Lookup is combinational on fetch_pc. A resolve report takes effect at the next rising clock edge, and a lookup of the same entry in the reporting cycle returns the old state.
- R10: In two-bit mode, a loop branch repeatedly encountered mispredicts once per encounter after the first, at loop exit.
- R11: In one-bit mode, the same loop mispredicts twice per encounter after the first: on its first iteration and at loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_one_bit | input | 1 | 1 selects one-bit last-outcome entries, 0 selects two-bit counters; changed only during reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Target buffer holds this address |
| pred_taken | output | 1 | Branch predicted taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_target | input | 32 | Real destination of the resolved branch |

## Verification
Both modes are swept after reset over a range of fetch addresses, then driven through a counter walk that climbs to the ceiling, steps down once, falls to the floor and climbs back. This separates hysteresis from last-outcome behaviour and shows saturation at both ends. A not-taken report at an address that shares a slot and a pattern entry with a trained branch shows whether the filter is honoured. A second branch that shares only the two-bit index shows that the extra index bit splits entries in one-bit mode. A repeated five-iteration loop compares the mispredict counts per encounter, one against two. A report and a lookup of the same address in one cycle confirm that the old value is returned.

// File: rtl/lbp_pkg.sv
`timescale 1ns/1ps
package lbp_pkg;

    localparam int unsigned INSTR_BYTES = 4;

    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'd0,
        CNT_WEAK_NT   = 2'd1,
        CNT_WEAK_T    = 2'd2,
        CNT_STRONG_T  = 2'd3
    } cnt2_e;

    // Pattern-table update kind: train an existing entry or seed a fresh one.
    typedef enum logic {
        PT_TRAIN = 1'b0,
        PT_SEED  = 1'b1
    } pt_op_e;

    function automatic logic [1:0] cnt2_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        if (up) begin
            nxt = (cur == CNT_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CNT_STRONG_NT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lbp_target_buf.sv
`timescale 1ns/1ps
module lbp_target_buf #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic [PC_W-1:0] up_pc,
    output logic            up_hit,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_target
);
    import lbp_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;
    localparam int ALIGN_W = $clog2(INSTR_BYTES);
    localparam int TAG_W   = PC_W - ALIGN_W - IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][PC_W-1:0]  target;
    } tb_state_t;

    tb_state_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [ENTRIES-1:0] lk_match, up_match;

    assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign up_idx = up_pc[ALIGN_W +: IDX_W];
    assign up_tag = up_pc[PC_W-1 -: TAG_W];

    // Per-slot tag comparators, then select by index.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign lk_match[e] = st_q.valid[e] && (st_q.tag[e] == lk_tag);
        assign up_match[e] = st_q.valid[e] && (st_q.tag[e] == up_tag);
    end

    assign lk_hit    = lk_match[lk_idx];
    assign up_hit    = up_match[up_idx];
    assign lk_target = st_q.target[lk_idx];

    logic unused_low;
    assign unused_low = ^{lk_pc[ALIGN_W-1:0], up_pc[ALIGN_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.valid[up_idx]  = 1'b1;
            st_d.tag[up_idx]    = up_tag;
            st_d.target[up_idx] = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lbp_pattern_tbl.sv
`timescale 1ns/1ps
module lbp_pattern_tbl #(
    parameter int PC_W       = 32,
    parameter int STORE_BITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_bit,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_taken,
    input  logic             up_en,
    input  lbp_pkg::pt_op_e  up_op,
    input  logic [PC_W-1:0]  up_pc,
    input  logic             up_taken
);
    import lbp_pkg::*;

    localparam int N2      = STORE_BITS / 2;
    localparam int IDX2_W  = $clog2(N2);
    localparam int IDX1_W  = IDX2_W + 1;
    localparam int ALIGN_W = $clog2(INSTR_BYTES);

    typedef struct packed {
        logic [STORE_BITS-1:0] bits;
    } pt_state_t;

    pt_state_t st_d, st_q;

    // Upper bit of each two-bit counter is its taken guess.
    logic [N2-1:0] cnt_msb;
    for (genvar g = 0; g < N2; g++) begin : g_msb
        assign cnt_msb[g] = st_q.bits[2*g+1];
    end

    logic [IDX1_W-1:0] lk_i1, up_i1;
    logic [IDX2_W-1:0] lk_i2, up_i2;
    logic [1:0]        up_cur;

    assign lk_i1 = lk_pc[ALIGN_W +: IDX1_W];
    assign lk_i2 = lk_pc[ALIGN_W +: IDX2_W];
    assign up_i1 = up_pc[ALIGN_W +: IDX1_W];
    assign up_i2 = up_pc[ALIGN_W +: IDX2_W];
    assign up_cur = st_q.bits[{up_i2, 1'b0} +: 2];

    assign lk_taken = one_bit ? st_q.bits[lk_i1] : cnt_msb[lk_i2];

    logic unused_pc;
    assign unused_pc = ^{lk_pc[PC_W-1:ALIGN_W+IDX1_W], lk_pc[ALIGN_W-1:0],
                         up_pc[PC_W-1:ALIGN_W+IDX1_W], up_pc[ALIGN_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (up_en) begin
            if (one_bit) begin
                st_d.bits[up_i1] = (up_op == PT_SEED) ? 1'b1 : up_taken;
            end else if (up_op == PT_SEED) begin
                st_d.bits[{up_i2, 1'b0} +: 2] = CNT_WEAK_T;
            end else begin
                st_d.bits[{up_i2, 1'b0} +: 2] = cnt2_step(up_cur, up_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lbp_top.sv
`timescale 1ns/1ps
module lbp_top #(
    parameter int PC_W          = 32,
    parameter int BTB_IDX_W     = 4,
    parameter int PT_STORE_BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_one_bit,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target
);
    import lbp_pkg::*;

    logic            tb_lk_hit;
    logic [PC_W-1:0] tb_lk_target;
    logic            tb_up_hit;
    logic            tb_wr;
    logic            pt_lk_taken;
    logic            pt_en;
    pt_op_e          pt_op;

    // Only taken branches write the buffer; not-taken misses are filtered out.
    assign tb_wr = res_valid && res_taken;
    assign pt_en = res_valid && (tb_up_hit || res_taken);
    assign pt_op = tb_up_hit ? PT_TRAIN : PT_SEED;

    lbp_target_buf #(
        .PC_W  (PC_W),
        .IDX_W (BTB_IDX_W)
    ) u_tbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (tb_lk_hit),
        .lk_target (tb_lk_target),
        .up_pc     (res_pc),
        .up_hit    (tb_up_hit),
        .wr_en     (tb_wr),
        .wr_target (res_target)
    );

    lbp_pattern_tbl #(
        .PC_W       (PC_W),
        .STORE_BITS (PT_STORE_BITS)
    ) u_ptbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .one_bit  (mode_one_bit),
        .lk_pc    (fetch_pc),
        .lk_taken (pt_lk_taken),
        .up_en    (pt_en),
        .up_op    (pt_op),
        .up_pc    (res_pc),
        .up_taken (res_taken)
    );

    assign pred_hit     = tb_lk_hit;
    assign pred_taken   = tb_lk_hit && pt_lk_taken;
    assign pred_next_pc = pred_taken ? tb_lk_target : fetch_pc + PC_W'(INSTR_BYTES);

endmodule

// File: rtl/lbp_checker.sv
`timescale 1ns/1ps
module lbp_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mode_one_bit,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic [PC_W-1:0] res_target
);

    a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_next_pc == fetch_pc + PC_W'(4)));

    a_r3_filtered_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken && !pred_hit && fetch_pc == res_pc)
        |=> (fetch_pc != $past(fetch_pc)) || !pred_hit);

    a_r4_alloc_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken && !pred_hit && fetch_pc == res_pc)
        |=> (fetch_pc != $past(fetch_pc))
            || (pred_taken && pred_next_pc == $past(res_target)));

    a_r5_hold_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_one_bit && res_valid && res_taken && pred_taken && fetch_pc == res_pc)
        |=> (fetch_pc != $past(fetch_pc)) || pred_taken);

    a_r6_last_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_one_bit && res_valid && fetch_pc == res_pc && (pred_hit || res_taken))
        |=> (fetch_pc != $past(fetch_pc))
            || (pred_hit && pred_taken == $past(res_taken)));

endmodule

bind lbp_top lbp_checker #(.PC_W(PC_W)) u_lbp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_one_bit (mode_one_bit),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .res_valid    (res_valid),
    .res_pc       (res_pc),
    .res_taken    (res_taken),
    .res_target   (res_target)
);

// File: tb/tb_lbp_top.sv
`timescale 1ns/1ps
module tb_lbp_top;
    localparam int PC_W = 32;
    localparam logic [31:0] PA = 32'h0000_1000;  // slot 0, pattern idx 0
    localparam logic [31:0] PB = 32'h0000_1040;  // same slot and pattern idx as PA, other tag
    localparam logic [31:0] PC = 32'h0000_1020;  // slot 8; shares PA's entry only in two-bit mode
    localparam logic [31:0] PL = 32'h0000_2040;  // loop branch
    localparam logic [31:0] T1 = 32'h0000_8000;
    localparam logic [31:0] T2 = 32'h0000_9000;
    localparam logic [31:0] T3 = 32'h0000_A000;
    localparam logic [31:0] TL = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_one_bit = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lbp_top #(.PC_W(PC_W), .BTB_IDX_W(4), .PT_STORE_BITS(16)) dut (
        .clk(clk), .rst_n(rst_n), .mode_one_bit(mode_one_bit),
        .fetch_pc(fetch_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_next_pc(pred_next_pc), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_target(res_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_one_bit = m;
        res_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic look(input logic [31:0] pc);
        @(negedge clk);
        fetch_pc = pc;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        fetch_pc = pc;
        res_valid = 1'b1;
        res_pc = pc;
        res_taken = tk;
        res_target = tgt;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
    endtask

    task automatic expect_pred(input string req, input logic [31:0] pc, input logic h,
                               input logic t, input logic [31:0] tgt);
        look(pc);
        check({req, " hit"}, {31'd0, pred_hit}, {31'd0, h});
        check({req, " taken"}, {31'd0, pred_taken}, {31'd0, t});
        check({req, " next"}, pred_next_pc, t ? tgt : pc + 32'd4);
    endtask

    task automatic run_mode(input logic m);
        int miss [3];
        apply_reset(m);
        // R1: reset sweep over 32 consecutive instruction slots
        for (int k = 0; k < 32; k++) begin
            expect_pred("R1 reset", 32'h0000_1000 + 32'(k) * 32'd4, 1'b0, 1'b0, 32'd0);
        end

        // R9: same-cycle lookup sees old state; R4: allocation visible after the edge
        @(negedge clk);
        fetch_pc = PA; res_valid = 1'b1; res_pc = PA; res_taken = 1'b1; res_target = T1;
        #1;
        check("R9 old value in report cycle", {31'd0, pred_hit}, 32'd0);
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        check("R4 alloc hit", {31'd0, pred_hit}, 32'd1);
        check("R4 alloc taken", {31'd0, pred_taken}, 32'd1);
        check("R4 alloc target", pred_next_pc, T1);

        if (!m) begin
            // R5 counter walk starting at weakly taken (2)
            resolve(PA, 1'b0, T1); expect_pred("R5 2->1", PA, 1'b1, 1'b0, T1);
            resolve(PA, 1'b1, T1); resolve(PA, 1'b1, T1); resolve(PA, 1'b1, T1);
            resolve(PA, 1'b0, T1); expect_pred("R5 hysteresis 3->2", PA, 1'b1, 1'b1, T1);
            resolve(PA, 1'b0, T1); expect_pred("R5 2->1", PA, 1'b1, 1'b0, T1);
            resolve(PA, 1'b0, T1); resolve(PA, 1'b0, T1); resolve(PA, 1'b0, T1);
            resolve(PA, 1'b1, T1); expect_pred("R5 floor 0->1", PA, 1'b1, 1'b0, T1);
            resolve(PA, 1'b1, T1); expect_pred("R5 1->2", PA, 1'b1, 1'b1, T1);
        end else begin
            resolve(PA, 1'b0, T1); expect_pred("R6 last not-taken", PA, 1'b1, 1'b0, T1);
            resolve(PA, 1'b1, T1); expect_pred("R6 last taken", PA, 1'b1, 1'b1, T1);
            resolve(PA, 1'b0, T1); expect_pred("R6 last not-taken", PA, 1'b1, 1'b0, T1);
            resolve(PA, 1'b1, T1); expect_pred("R6 last taken", PA, 1'b1, 1'b1, T1);
        end

        // R7: destination replaced on taken hit
        resolve(PA, 1'b1, T2);
        expect_pred("R7 new target", PA, 1'b1, 1'b1, T2);
        if (!m) begin
            resolve(PA, 1'b0, T2);   // counter 3 -> 2
            expect_pred("R5 one exit keeps taken", PA, 1'b1, 1'b1, T2);
        end

        // R3: not-taken miss at an aliasing address leaves both structures untouched
        resolve(PB, 1'b0, T3);
        expect_pred("R3 no alloc", PB, 1'b0, 1'b0, 32'd0);
        expect_pred("R3 pattern untouched", PA, 1'b1, 1'b1, T2);

        // R8: PC shares PA's pattern entry only in two-bit mode
        resolve(PC, 1'b1, T3);
        expect_pred("R8 second branch", PC, 1'b1, 1'b1, T3);
        resolve(PC, 1'b0, T3);
        expect_pred("R8 index sharing", PA, 1'b1, m, T2);

        // R10 / R11: loop of five iterations, three encounters
        apply_reset(m);
        for (int e = 0; e < 3; e++) begin
            miss[e] = 0;
            for (int it = 0; it < 5; it++) begin
                logic act;
                logic pt;
                act = (it < 4);
                look(PL);
                pt = pred_taken;
                if (pt != act) miss[e]++;
                else if (pt && pred_next_pc != TL) miss[e]++;
                resolve(PL, act, TL);
            end
        end
        check(m ? "R11 first encounter" : "R10 first encounter", 32'(miss[0]), 32'd2);
        check(m ? "R11 second encounter" : "R10 second encounter", 32'(miss[1]), m ? 32'd2 : 32'd1);
        check(m ? "R11 third encounter" : "R10 third encounter", 32'(miss[2]), m ? 32'd2 : 32'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

endmodule